// File: doc/BRIEF.md
# Three-Word Key Unlock Sequencer

This block guards a protected information region behind a write-only key register. Software must write three specific 32-bit words to the key register, in a fixed order. Only then does the block raise a single access-granted output, which downstream logic uses to gate reads and writes of the protected region. The region itself lies outside this block.

A wrong word at any step sends the sequence back to its start. The exception is a wrong word that equals the first key word: it is taken as the opening step of a fresh attempt. While access is granted, any write to the key register, whatever its value, takes access away. That relocking write is not counted toward a new attempt. Writes to other register offsets pass through without touching the sequence. Reading the key register always returns zero, so the keys cannot be recovered by reading back.

Top module: `key_unlock_seq`

## Requirements
- R1: After reset, `access_granted` is 0 and the sequence waits for the first key word.
- R2: A key-register write of the first key word (default 0x3A7F5CA3) while waiting for the first word advances to the second step. A write of the second key word (default 0xA1E34F20) advances to the third step only when it directly follows the first.
- R3: A key-register write of the third key word (default 0x9608B2C1) at the third step sets `access_granted` to 1 on the clock edge that samples the write. The output is visible in the cycle after the write.
- R4: A key-register write that does not match the expected word at the first, second or third step returns the sequence to its first step. If that word equals the first key word, the sequence is at the second step instead.
- R5: While `access_granted` is 1, a key-register write of any value clears `access_granted` in the following cycle. The next attempt must then start with the first key word; the relocking write itself does not count as step one.
- R6: `key_rdata`, the read-back value of the key register, is always zero, including while access is granted.
- R7: Writes whose `wr_addr` differs from the key offset (default 0x40) neither advance nor reset the sequence, and they do not change `access_granted`.
- R8: Once set, `access_granted` stays 1 until a key-register write or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register offset of the write |
| wr_data | input | 32 | Write data |
| key_rdata | output | 32 | Read-back value of the key register (always zero) |
| access_granted | output | 1 | Registered grant for the protected region |

## Verification
Two things can fall on the same write: restarting after a wrong word, and recognizing the first key word. A write of the first key word at the second or third step must both abandon the attempt in progress and count as step one. The bench provokes this with directed writes such as first-first-second-third, which must grant. Random traffic weighted toward key words also produces it often. The relock-versus-first-key case is provoked by writing the first key word while unlocked. A bench model judges both cases by computing the expected step and grant after every write and comparing the grant one cycle later.

// File: rtl/key_unlock_seq.sv
module key_unlock_seq #(
  parameter int          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] KEY_OFFSET = 8'h40,
  parameter logic [31:0] KEY_A      = 32'h3A7F5CA3,
  parameter logic [31:0] KEY_B      = 32'hA1E34F20,
  parameter logic [31:0] KEY_C      = 32'h9608B2C1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       key_rdata,
  output logic              access_granted
);

  typedef enum logic [1:0] {WAIT_A, WAIT_B, WAIT_C, OPEN} step_t;

  step_t step_q, step_d;
  logic  key_wr;

  assign key_wr    = wr_en && (wr_addr == KEY_OFFSET);
  assign key_rdata = '0;
  assign access_granted = (step_q == OPEN);

  always_comb begin
    step_d = step_q;
    if (key_wr) begin
      unique case (step_q)
        WAIT_A:  step_d = (wr_data == KEY_A) ? WAIT_B : WAIT_A;
        WAIT_B:  step_d = (wr_data == KEY_B) ? WAIT_C :
                          (wr_data == KEY_A) ? WAIT_B : WAIT_A;
        WAIT_C:  step_d = (wr_data == KEY_C) ? OPEN   :
                          (wr_data == KEY_A) ? WAIT_B : WAIT_A;
        default: step_d = WAIT_A;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= WAIT_A;
    else        step_q <= step_d;
  end

  assert_grant_on_third_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && step_q == WAIT_C && wr_data == KEY_C) |=> access_granted);

  assert_grant_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_granted) |-> $past(key_wr && wr_data == KEY_C));

  assert_relock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (access_granted && key_wr) |=> (!access_granted && step_q == WAIT_A));

  assert_hold_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (access_granted && !key_wr) |=> access_granted);

  assert_other_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_wr) |=> $stable(step_q));

  assert_first_key_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wr_data == KEY_A && step_q != OPEN) |=> (step_q == WAIT_B));

endmodule

// File: tb/key_unlock_seq_tb.sv
module key_unlock_seq_tb_top;
  localparam logic [7:0]  OFS = 8'h40;
  localparam logic [31:0] KA = 32'h3A7F5CA3, KB = 32'hA1E34F20, KC = 32'h9608B2C1;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_addr = 0;
  logic [31:0] wr_data = 0, key_rdata;
  logic access_granted;
  int checks = 0, errors = 0, mstep = 0;

  always #10 clk = ~clk;

  key_unlock_seq dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .key_rdata(key_rdata), .access_granted(access_granted));

  function automatic int next_step(int s, logic [7:0] a, logic [31:0] d);
    if (a != OFS) return s;
    case (s)
      0: return (d == KA) ? 1 : 0;
      1: return (d == KB) ? 2 : (d == KA) ? 1 : 0;
      2: return (d == KC) ? 3 : (d == KA) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(logic [7:0] a, logic [31:0] d, string req);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    mstep = next_step(mstep, a, d);
    check(req, {31'b0, access_granted}, {31'b0, mstep == 3});
    check("R6", key_rdata, 32'h0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r;
    logic [7:0] a;
    logic [31:0] d;
    r = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    check("R1", {31'b0, access_granted}, 32'h0);
    check("R6", key_rdata, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1", {31'b0, access_granted}, 32'h0);
    do_wr(OFS, KB, "R1");
    do_wr(OFS, KA, "R2");
    do_wr(OFS, KB, "R2");
    do_wr(OFS, KC, "R3");
    do_wr(8'h08, 32'h0, "R7");
    check("R8", {31'b0, access_granted}, 32'h1);
    do_wr(OFS, KA, "R5");
    do_wr(OFS, KB, "R5");
    do_wr(OFS, KC, "R5");
    do_wr(OFS, KA, "R4"); do_wr(OFS, KA, "R4");
    do_wr(OFS, KB, "R4"); do_wr(OFS, KA, "R4");
    do_wr(OFS, KB, "R4"); do_wr(OFS, KC, "R4");
    do_wr(OFS, 32'h0, "R5");
    do_wr(OFS, KA, "R7"); do_wr(8'h00, KC, "R7");
    do_wr(8'h44, 32'hFFFFFFFF, "R7"); do_wr(OFS, KB, "R7");
    do_wr(OFS, KC, "R7");
    do_wr(OFS, KA, "R2"); do_wr(OFS, KC, "R4"); do_wr(OFS, KB, "R4");
    for (int i = 0; i < 4000; i++) begin
      r = $urandom_range(0, 9);
      a = (r < 8) ? OFS : 8'($urandom_range(0, 255));
      r = $urandom_range(0, 9);
      d = (r < 3) ? KA : (r < 5) ? KB : (r < 7) ? KC : $urandom;
      do_wr(a, d, "R4");
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        check("R8", {31'b0, access_granted}, {31'b0, mstep == 3});
      end
    end
    rst_n = 0;
    @(negedge clk);
    mstep = 0;
    check("R1", {31'b0, access_granted}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    do_wr(OFS, KB, "R1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule